// File: doc/BRIEF.md
# Double-Buffered Peripheral-to-Memory Transfer Channel

This block moves words from one peripheral data source into memory, one word per peripheral request. The peripheral side is a single fixed source; the memory side is an address pointer that either steps by one per word or stays put. A 16-bit remaining-word counter tracks the current block, and a block ends when that counter reaches zero.

The channel holds two memory base registers and a target-select bit that names which base the channel is writing. In single mode the end of a block disables the channel. In ping-pong mode the channel keeps running: the target bit flips, the counter reloads from the programmed length, and the pointer restarts at the other base. Software can therefore capture a stream far longer than one block by rewriting the idle base while the active one fills. Completion and error flags are cleared by writing ones, each has an interrupt enable, and a stop request halts the channel one cycle late.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset the channel is idle (busy 0), mem_we is 0, cur_tgt is 0, remaining is 0, and tc_flag, err_flag and irq are 0.
- R2: A start pulse while idle with a nonzero cfg_len makes busy 1, cur_tgt 0 and remaining equal to cfg_len after the next clock edge; a start with cfg_len of 0 is ignored and busy stays 0.
- R3: Each cycle in which the channel is busy and per_req is 1 produces exactly one memory write on the following cycle, at the current pointer, carrying the per_data sampled with the request; the pointer then steps by one if cfg_minc was 1 at start, else it holds.
- R4: Each accepted word lowers remaining by one; accepting the word taken when remaining is 1 is the block end and sets tc_flag.
- R5: In single mode (cfg_dbm 0 at start) a block end clears busy and leaves remaining at 0; later requests produce no memory write.
- R6: In ping-pong mode (cfg_dbm 1 at start) a block end flips cur_tgt, reloads remaining from cfg_len, keeps busy 1, and the next word is written at the base selected by the new cur_tgt.
- R7: A base write (base_we, base_sel 0 or 1) to the base not currently targeted is accepted at any time, including the cycle of a block end, in which case the next block starts at the newly written value.
- R8: While busy, a base write whose base_sel equals cur_tgt is ignored and sets err_flag.
- R9: flag_clr bit 0 clears tc_flag and bit 1 clears err_flag; a flag being set in the same cycle as its clear stays set.
- R10: irq equals (tc_flag and cfg_tcie) or (err_flag and cfg_teie), with the enables captured at start.
- R11: After a stop_req pulse while busy, busy stays 1 for one more cycle and falls after the second clock edge; requests in that extra cycle produce no memory write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only while idle |
| cfg_len | input | CW | Words per block |
| cfg_dbm | input | 1 | 1 selects ping-pong mode |
| cfg_minc | input | 1 | 1 steps the memory pointer per word |
| cfg_tcie | input | 1 | Completion interrupt enable |
| cfg_teie | input | 1 | Error interrupt enable |
| base_we | input | 1 | Base register write strobe |
| base_sel | input | 1 | Base register select |
| base_wdata | input | AW | Base register value |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 completion, bit 1 error |
| stop_req | input | 1 | Stop request pulse |
| per_req | input | 1 | Peripheral word available |
| per_data | input | DW | Peripheral word |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| busy | output | 1 | Channel running |
| cur_tgt | output | 1 | Base currently targeted |
| remaining | output | CW | Words left in the current block |
| tc_flag | output | 1 | Block-end flag |
| err_flag | output | 1 | Rejected base write flag |
| irq | output | 1 | Interrupt |

## Verification
The embedded properties watch, on every cycle, that a memory write only follows an accepted request, that a single-mode block end drops busy, that a ping-pong block end reloads the counter while staying busy, that a rejected base write raises the error flag and that a set event survives a simultaneous clear. Only the scenarios show the address sequences themselves: which base each block lands at after rewrites, that a write to the active base leaves later blocks unaffected, that a base written in the swap cycle is forwarded, and the stop timing.

// File: rtl/dbuf_dma_pkg.sv
package dbuf_dma_pkg;
  localparam int FLAG_N  = 2;
  localparam int FLAG_TC = 0;
  localparam int FLAG_ER = 1;
  typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/dbuf_dma_ptr.sv
module dbuf_dma_ptr #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  input  logic          beat,
  input  logic          minc,
  input  logic          dbm,
  input  logic          running,
  input  logic          base_we,
  input  logic          base_sel,
  input  logic [AW-1:0] base_wdata,
  output logic [AW-1:0] ptr,
  output logic [CW-1:0] cnt,
  output logic          ct,
  output logic          last,
  output logic          bad_wr
);
  localparam int NBASE = 2;

  logic [AW-1:0] base_q [NBASE];
  logic [CW-1:0] len_q;
  logic          base_ok;
  logic [AW-1:0] nxt_base;

  assign bad_wr  = base_we && running && (base_sel == ct);
  assign base_ok = base_we && !bad_wr;
  assign last    = (cnt == CW'(1));
  assign nxt_base = (base_ok && (base_sel == !ct)) ? base_wdata : base_q[!ct];

  for (genvar i = 0; i < NBASE; i++) begin : g_base
    always_ff @(posedge clk) begin
      if (rst) base_q[i] <= '0;
      else if (base_ok && (base_sel == 1'(i))) base_q[i] <= base_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ct    <= 1'b0;
      cnt   <= '0;
      ptr   <= '0;
      len_q <= '0;
    end else if (load) begin
      ct    <= 1'b0;
      cnt   <= len;
      len_q <= len;
      ptr   <= base_q[0];
    end else if (beat) begin
      if (last && dbm) begin
        ct  <= !ct;
        cnt <= len_q;
        ptr <= nxt_base;
      end else begin
        cnt <= cnt - CW'(1);
        if (minc) ptr <= ptr + AW'(1);
      end
    end
  end

  // R6: a ping-pong block end reloads the counter from the programmed length
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (beat && last && dbm) |=> (cnt == len_q));
  // R4: the counter never underflows past zero while words are accepted
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    beat |-> (cnt != '0));
endmodule

// File: rtl/dbuf_dma_flags.sv
module dbuf_dma_flags
  import dbuf_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_vec_t set,
  input  flag_vec_t clr,
  input  logic      tcie,
  input  logic      teie,
  output logic      tc_flag,
  output logic      err_flag,
  output logic      irq
);
  flag_vec_t flg;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flg[i] <= 1'b0;
      else if (set[i]) flg[i] <= 1'b1;
      else if (clr[i]) flg[i] <= 1'b0;
    end
  end

  assign tc_flag  = flg[FLAG_TC];
  assign err_flag = flg[FLAG_ER];
  assign irq      = (tc_flag && tcie) || (err_flag && teie);

  // R9: a set in the same cycle as a clear leaves the flag set
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (set[FLAG_TC] && clr[FLAG_TC]) |=> tc_flag);
  // R9: a clear with no set drops the flag
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr[FLAG_ER] && !set[FLAG_ER]) |=> !err_flag);
endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
  import dbuf_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] cfg_len,
  input  logic          cfg_dbm,
  input  logic          cfg_minc,
  input  logic          cfg_tcie,
  input  logic          cfg_teie,
  input  logic          base_we,
  input  logic          base_sel,
  input  logic [AW-1:0] base_wdata,
  input  logic [1:0]    flag_clr,
  input  logic          stop_req,
  input  logic          per_req,
  input  logic [DW-1:0] per_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          cur_tgt,
  output logic [CW-1:0] remaining,
  output logic          tc_flag,
  output logic          err_flag,
  output logic          irq
);
  logic running, stop_pend;
  logic dbm_q, minc_q, tcie_q, teie_q;
  logic load, beat, last, bad_wr;
  logic [AW-1:0] ptr;
  flag_vec_t fset;

  assign load = start && !running && (cfg_len != '0);
  assign beat = running && per_req && !stop_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      stop_pend <= 1'b0;
      dbm_q     <= 1'b0;
      minc_q    <= 1'b0;
      tcie_q    <= 1'b0;
      teie_q    <= 1'b0;
    end else begin
      if (load) begin
        running <= 1'b1;
        dbm_q   <= cfg_dbm;
        minc_q  <= cfg_minc;
        tcie_q  <= cfg_tcie;
        teie_q  <= cfg_teie;
      end else if (stop_pend) begin
        running <= 1'b0;
      end else if (beat && last && !dbm_q) begin
        running <= 1'b0;
      end
      if (stop_pend)                stop_pend <= 1'b0;
      else if (stop_req && running) stop_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= beat;
      if (beat) begin
        mem_addr  <= ptr;
        mem_wdata <= per_data;
      end
    end
  end

  dbuf_dma_ptr #(.AW(AW), .CW(CW)) u_ptr (
    .clk(clk), .rst(rst), .load(load), .len(cfg_len), .beat(beat),
    .minc(minc_q), .dbm(dbm_q), .running(running),
    .base_we(base_we), .base_sel(base_sel), .base_wdata(base_wdata),
    .ptr(ptr), .cnt(remaining), .ct(cur_tgt), .last(last), .bad_wr(bad_wr)
  );

  always_comb begin
    fset          = '0;
    fset[FLAG_TC] = beat && last;
    fset[FLAG_ER] = bad_wr;
  end

  dbuf_dma_flags u_flags (
    .clk(clk), .rst(rst), .set(fset), .clr(flag_clr),
    .tcie(tcie_q), .teie(teie_q),
    .tc_flag(tc_flag), .err_flag(err_flag), .irq(irq)
  );

  assign busy = running;

  // R3: a memory write only follows an accepted request
  p_write_follows_req_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(running && per_req));
  // R5: a single-mode block end takes the channel out of busy
  p_single_end_r5: assert property (@(posedge clk) disable iff (rst)
    (beat && last && !dbm_q) |=> !busy);
  // R6: a ping-pong block end keeps the channel busy and flips the target
  p_pingpong_r6: assert property (@(posedge clk) disable iff (rst)
    (beat && last && dbm_q && !stop_pend) |=> (busy && (cur_tgt != $past(cur_tgt))));
  // R8: a write to the active base while busy raises the error flag
  p_active_wr_r8: assert property (@(posedge clk) disable iff (rst)
    (base_we && busy && (base_sel == cur_tgt)) |=> err_flag);
  // R11: busy survives the cycle after a stop request
  p_stop_late_r11: assert property (@(posedge clk) disable iff (rst)
    (stop_req && busy && !stop_pend && !(beat && last && !dbm_q) && !load) |=> busy);
endmodule

// File: tb/tb_dbuf_dma_chan.sv
module tb_dbuf_dma_chan;
  localparam int AW = 16, DW = 16, CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 0, cfg_dbm = 0, cfg_minc = 0, cfg_tcie = 0, cfg_teie = 0;
  logic [CW-1:0] cfg_len = '0;
  logic base_we = 0, base_sel = 0;
  logic [AW-1:0] base_wdata = '0;
  logic [1:0] flag_clr = '0;
  logic stop_req = 0, per_req = 0;
  logic [DW-1:0] per_data = '0;
  logic mem_we, busy, cur_tgt, tc_flag, err_flag, irq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [CW-1:0] remaining;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dbuf_dma_chan #(.AW(AW), .DW(DW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .start(start), .cfg_len(cfg_len), .cfg_dbm(cfg_dbm),
    .cfg_minc(cfg_minc), .cfg_tcie(cfg_tcie), .cfg_teie(cfg_teie),
    .base_we(base_we), .base_sel(base_sel), .base_wdata(base_wdata),
    .flag_clr(flag_clr), .stop_req(stop_req), .per_req(per_req), .per_data(per_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
    .cur_tgt(cur_tgt), .remaining(remaining), .tc_flag(tc_flag),
    .err_flag(err_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_base(input bit sel, input int val);
    base_we = 1; base_sel = sel; base_wdata = AW'(val);
    @(negedge clk);
    base_we = 0;
  endtask

  task automatic do_start(input int len, input bit dbm, input bit minc, input bit tcie, input bit teie);
    start = 1; cfg_len = CW'(len); cfg_dbm = dbm; cfg_minc = minc;
    cfg_tcie = tcie; cfg_teie = teie;
    @(negedge clk);
    start = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    summary();
  end

  initial begin
    int eb[5];
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_we && !cur_tgt, "R1 idle outputs", {busy, mem_we, cur_tgt}, 0);
    chk(remaining == 0, "R1 remaining", remaining, 0);
    chk(!tc_flag && !err_flag && !irq, "R1 flags", {tc_flag, err_flag, irq}, 0);

    // R2 zero length start ignored
    do_start(0, 0, 1, 1, 0);
    chk(!busy, "R2 zero length ignored", busy, 0);

    // single mode sweep: R2 R3 R4 R5 R10 R9
    for (int L = 1; L <= 4; L++) begin
      bit mi;
      int b0;
      mi = (L != 3);
      b0 = 'h40 * L;
      wr_base(0, b0);
      do_start(L, 0, mi, 1, 0);
      chk(busy && !cur_tgt, "R2 busy after start", {busy, cur_tgt}, 2);
      chk(remaining == CW'(L), "R2 remaining loaded", remaining, L);
      for (int k = 0; k < L; k++) begin
        per_req = 1; per_data = DW'('h500 + 16 * L + k);
        @(negedge clk);
        per_req = 0;
        chk(mem_we, "R3 write strobe", mem_we, 1);
        chk(mem_addr == AW'(b0 + (mi ? k : 0)), "R3 address", mem_addr, b0 + (mi ? k : 0));
        chk(mem_wdata == DW'('h500 + 16 * L + k), "R3 data", mem_wdata, 'h500 + 16 * L + k);
        chk(remaining == CW'(L - 1 - k), "R4 countdown", remaining, L - 1 - k);
      end
      chk(!busy, "R5 single end idle", busy, 0);
      chk(tc_flag, "R4 block end flag", tc_flag, 1);
      chk(irq, "R10 completion irq", irq, 1);
      per_req = 1;
      @(negedge clk);
      per_req = 0;
      @(negedge clk);
      chk(!mem_we, "R5 no write after end", mem_we, 0);
      flag_clr = 2'b01;
      @(negedge clk);
      flag_clr = 2'b00;
      chk(!tc_flag && !irq, "R9 tc cleared", {tc_flag, irq}, 0);
    end

    // ping-pong: R6 R7 R8 R9 R10
    begin
      int L;
      L = 3;
      eb[0] = 'h100; eb[1] = 'h200; eb[2] = 'h300; eb[3] = 'h400; eb[4] = 'h300;
      wr_base(0, 'h100);
      wr_base(1, 'h200);
      do_start(L, 1, 1, 0, 1);
      for (int g = 0; g <= 4 * L; g++) begin
        int blk, off;
        blk = g / L; off = g % L;
        per_req = 1; per_data = DW'('hA000 + g);
        if (blk == 1 && off == 1) begin base_we = 1; base_sel = 0; base_wdata = 'h300; end
        if (blk == 2 && off == 0) begin base_we = 1; base_sel = 0; base_wdata = 'h999; flag_clr = 2'b01; end
        if (blk == 2 && off == L - 1) begin base_we = 1; base_sel = 1; base_wdata = 'h400; end
        if (blk == 3 && off == L - 1) flag_clr = 2'b01;
        @(negedge clk);
        base_we = 0; flag_clr = 2'b00;
        chk(mem_we && mem_addr == AW'(eb[blk] + off), "R6 R7 R8 block address", mem_addr, eb[blk] + off);
        chk(mem_wdata == DW'('hA000 + g), "R3 ping-pong data", mem_wdata, 'hA000 + g);
        if (off == L - 1) begin
          chk(busy && cur_tgt == ((blk + 1) % 2), "R6 target flips, stays busy", {busy, cur_tgt}, 2 + (blk + 1) % 2);
          chk(remaining == CW'(L), "R6 counter reload", remaining, L);
          chk(tc_flag, "R9 set wins over clear", tc_flag, 1);
        end
        if (blk == 2 && off == 0) begin
          chk(err_flag, "R8 active base write flagged", err_flag, 1);
          chk(!tc_flag, "R9 tc cleared", tc_flag, 0);
          chk(irq, "R10 error irq", irq, 1);
        end
      end
      per_req = 0;
      flag_clr = 2'b10;
      @(negedge clk);
      flag_clr = 2'b00;
      chk(!err_flag && tc_flag && !irq, "R10 masked completion", {err_flag, tc_flag, irq}, 2);

      // R11 stop timing
      stop_req = 1;
      @(negedge clk);
      stop_req = 0; per_req = 1;
      chk(busy, "R11 busy one cycle after stop", busy, 1);
      @(negedge clk);
      per_req = 0;
      chk(!busy, "R11 idle after second edge", busy, 0);
      chk(!mem_we, "R11 no write during stop", mem_we, 0);
    end
    summary();
  end
endmodule